// File: doc/BRIEF.md
# Multiprocessor Interrupt Aggregator with Mailboxes

This block gathers the interrupt requests of a small multiprocessor into one memory-mapped register file. Level-sensitive device lines are captured into a raw pending word. Software mailbox requests between processors sit in a second raw word, which holds two request bits for each CPU. Each CPU owns a bank of enable words. Its source words are the raw words masked by those enables, and its interrupt output is high while any of its source bits is set. Every bit-vector register has a plain view, a write-one-to-set alias and a write-one-to-clear alias. A CPU can therefore change single bits without a read-modify-write race against the other processors.

The register port is a 32-bit request/response stream with valid/ready on both sides. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Every accepted request, read or write, returns exactly one response beat one cycle later. A write returns zero data. A response stays on the port, unchanged, until `rsp_ready` is seen high. While a response is waiting and `rsp_ready` is low, `req_ready` is low, so a slow consumer stalls the requester. Nothing is dropped.

Group spacing is SP = 8*(1+((NBITS-1)/64)) bytes. With the defaults SP is 8. Offset 0 returns the implemented bit count. Three global groups start at byte 8, in this order: raw, raw-set, raw-clear. The per-CPU groups start at 8+3*SP, in this order: source, enable, enable-set, enable-clear. CPU c's copy of a per-CPU group lies c*4*SP bytes above CPU 0's copy. Inside every group, the word at +0 holds the device lines (bit i = `dev_irq[i]`). The word at +4 holds the mailbox bits, where mailbox m of CPU c is bit 2*c+m.

Top module: `irq_aggregator`

## Requirements
- R1: A read of byte offset 0 returns NBITS (32 by default). Writes there have no effect.
- R2: Raw word 0 (offset 8) equals `dev_irq`, delayed by one clock. Writes to offsets 8, 16 and 24 do not change it.
- R3: A write to raw-set word 1 (offset 20) sets each mailbox bit written as 1. A write to raw-clear word 1 (offset 28) clears each such bit. Bits written as 0 keep their value. A write to plain raw word 1 (offset 12) is ignored. Both aliases read back the raw mailbox word.
- R4: For CPU c, the plain enable word loads the write data. It sits at 8+4*SP+c*4*SP, +4 for mailboxes. The enable-set alias (+SP from it) sets bits written as 1, and the enable-clear alias (+2*SP) clears them. Device enables keep only NDEV bits, so with the defaults a write of 0xFF reads back 0xF.
- R5: CPU c's source words (offset 8+3*SP+c*4*SP, +4 for mailboxes) read raw AND that CPU's enable. Writes to them are ignored.
- R6: `cpu_irq[c]` is high exactly when either source word of CPU c is nonzero. It follows state changes in the same cycle as the register update.
- R7: Reads of unmapped offsets return zero, and writes to them change no state. This covers offset 4, the unused words of a group, and everything past the last CPU bank.
- R8: Reset clears all enables, all mailbox bits, the raw device word, `rsp_valid` and `cpu_irq`.
- R9: Each accepted request yields one response in the next cycle. A response is held stable while `rsp_ready` is low, and no new request is accepted during that time.
- R10: Each CPU's bank is independent. A write to one CPU's enable words leaves every other CPU's enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | NDEV | Level-sensitive device interrupt lines |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address (bits 1:0 ignored) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| cpu_irq | output | NCPU | Interrupt request, one per CPU |

## Verification
The bench aims at the aliasing corners of the map. It checks that a set or clear alias touches only the bits written as 1; a design that treated the alias as a plain store would wipe the neighbouring mailbox bits. It checks that writes to the raw device word, the plain raw mailbox word and the source words leave state alone; a decoder that let those through would hide or fake pending interrupts. It also checks that one CPU's enable write does not show up in another CPU's bank, and that a 0xFF write to the device enables is trimmed to the four implemented lines. Under back-pressure, it checks that a held response neither changes nor gets overwritten by a second request, which a design that accepted requests blindly would do. It checks the one-cycle lag from a device line to the interrupt output.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

  // Register group selected by a decoded address.
  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_COUNT,
    SEL_RAW,
    SEL_RAW_SET,
    SEL_RAW_CLR,
    SEL_SRC,
    SEL_EN,
    SEL_EN_SET,
    SEL_EN_CLR
  } reg_sel_e;

  // word1 = 0: device word, word1 = 1: mailbox word.
  typedef struct packed {
    reg_sel_e   sel;
    logic       word1;
    logic [7:0] cpu;
  } reg_dec_t;

  localparam int GROUP_BASE = 8;

  // Byte distance between consecutive register groups.
  function automatic int group_spacing(input int nbits);
    return 8 * (1 + ((nbits - 1) / 64));
  endfunction

endpackage

// File: rtl/irq_aggr_decode.sv
module irq_aggr_decode
  import irq_aggr_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int NBITS = 32,
  parameter int AW    = 12
) (
  input  logic [AW-1:0] addr,
  output reg_dec_t      dec
);

  localparam int SPACING    = group_spacing(NBITS);
  localparam int CPU_STRIDE = 4 * SPACING;
  localparam int BANK_BASE  = GROUP_BASE + 3 * SPACING;
  localparam int BANK_END   = BANK_BASE + NCPU * CPU_STRIDE;

  int a_int;
  int rel;
  int slot;
  int wrd;

  always_comb begin
    a_int     = int'(addr);
    rel       = 0;
    slot      = 0;
    wrd       = 0;
    dec       = '0;
    dec.sel   = SEL_NONE;
    if (a_int < 4) begin
      dec.sel = SEL_COUNT;
    end else if (a_int >= GROUP_BASE && a_int < BANK_BASE) begin
      // global raw groups: raw, raw-set, raw-clear
      rel  = a_int - GROUP_BASE;
      slot = rel / SPACING;
      wrd  = (rel % SPACING) / 4;
      if (wrd < 2) begin
        dec.word1 = (wrd == 1);
        case (slot)
          0:       dec.sel = SEL_RAW;
          1:       dec.sel = SEL_RAW_SET;
          default: dec.sel = SEL_RAW_CLR;
        endcase
      end
    end else if (a_int >= BANK_BASE && a_int < BANK_END) begin
      // per-CPU groups: source, enable, enable-set, enable-clear
      rel  = a_int - BANK_BASE;
      slot = rel / SPACING;
      wrd  = (rel % SPACING) / 4;
      if (wrd < 2) begin
        dec.word1 = (wrd == 1);
        dec.cpu   = 8'(slot / 4);
        case (slot % 4)
          0:       dec.sel = SEL_SRC;
          1:       dec.sel = SEL_EN;
          2:       dec.sel = SEL_EN_SET;
          default: dec.sel = SEL_EN_CLR;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_aggr_raw.sv
module irq_aggr_raw #(
  parameter int NDEV = 4,
  parameter int MBW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] dev_in,
  input  logic            mb_set_we,
  input  logic            mb_clr_we,
  input  logic [MBW-1:0]  mb_wdata,
  output logic [NDEV-1:0] raw_dev,
  output logic [MBW-1:0]  raw_mb
);

  // Device lines are level-sensitive: captured every cycle, never written.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_dev <= '0;
    else        raw_dev <= dev_in;
  end

  // Mailbox bits only move on alias writes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         raw_mb <= '0;
    else if (mb_set_we) raw_mb <= raw_mb | mb_wdata;
    else if (mb_clr_we) raw_mb <= raw_mb & ~mb_wdata;
  end

  a_r2_dev_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> raw_dev == $past(dev_in));

  a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    mb_set_we |=> (raw_mb & $past(mb_wdata)) == $past(mb_wdata));

  a_r3_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_clr_we && !mb_set_we) |=> (raw_mb & $past(mb_wdata)) == '0);

  a_r3_mb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mb_set_we && !mb_clr_we) |=> $stable(raw_mb));

endmodule

// File: rtl/irq_aggr_enable.sv
module irq_aggr_enable #(
  parameter int NDEV = 4,
  parameter int MBW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic            word1,
  input  logic [31:0]     wdata,
  output logic [NDEV-1:0] en_dev,
  output logic [MBW-1:0]  en_mb
);

  logic [NDEV-1:0] wd_dev;
  logic [MBW-1:0]  wd_mb;

  assign wd_dev = wdata[NDEV-1:0];
  assign wd_mb  = wdata[MBW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_dev <= '0;
    end else if (!word1) begin
      if (we)          en_dev <= wd_dev;
      else if (set_we) en_dev <= en_dev | wd_dev;
      else if (clr_we) en_dev <= en_dev & ~wd_dev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mb <= '0;
    end else if (word1) begin
      if (we)          en_mb <= wd_mb;
      else if (set_we) en_mb <= en_mb | wd_mb;
      else if (clr_we) en_mb <= en_mb & ~wd_mb;
    end
  end

  a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !we && word1) |=> (en_mb & $past(wd_mb)) == $past(wd_mb));

  a_r4_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !we && !set_we && !word1) |=> (en_dev & $past(wd_dev)) == '0);

  a_r4_other_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
    word1 |=> $stable(en_dev));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_aggr_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int NBITS = 32,
  parameter int NDEV  = 4,
  parameter int AW    = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDEV-1:0] dev_irq,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [31:0]     req_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [31:0]     rsp_rdata,
  output logic [NCPU-1:0] cpu_irq
);

  localparam int MBW = 2 * NCPU;
  localparam int CW  = (NCPU > 1) ? $clog2(NCPU) : 1;

  reg_dec_t        dec;
  logic            acc;
  logic            wr_acc;
  logic [CW-1:0]   cpu_idx;
  logic [NDEV-1:0] raw_dev;
  logic [MBW-1:0]  raw_mb;
  logic [NDEV-1:0] en_dev_a [NCPU];
  logic [MBW-1:0]  en_mb_a  [NCPU];
  logic [NDEV-1:0] src_dev_a [NCPU];
  logic [MBW-1:0]  src_mb_a  [NCPU];
  logic [31:0]     rd_data;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign cpu_idx   = dec.cpu[CW-1:0];

  irq_aggr_decode #(
    .NCPU (NCPU),
    .NBITS(NBITS),
    .AW   (AW)
  ) u_decode (
    .addr(req_addr),
    .dec (dec)
  );

  irq_aggr_raw #(
    .NDEV(NDEV),
    .MBW (MBW)
  ) u_raw (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_in   (dev_irq),
    .mb_set_we(wr_acc && dec.sel == SEL_RAW_SET && dec.word1),
    .mb_clr_we(wr_acc && dec.sel == SEL_RAW_CLR && dec.word1),
    .mb_wdata (req_wdata[MBW-1:0]),
    .raw_dev  (raw_dev),
    .raw_mb   (raw_mb)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic hit;
    assign hit = wr_acc && (dec.cpu == 8'(c));

    irq_aggr_enable #(
      .NDEV(NDEV),
      .MBW (MBW)
    ) u_enable (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (hit && dec.sel == SEL_EN),
      .set_we(hit && dec.sel == SEL_EN_SET),
      .clr_we(hit && dec.sel == SEL_EN_CLR),
      .word1 (dec.word1),
      .wdata (req_wdata),
      .en_dev(en_dev_a[c]),
      .en_mb (en_mb_a[c])
    );

    assign src_dev_a[c] = raw_dev & en_dev_a[c];
    assign src_mb_a[c]  = raw_mb & en_mb_a[c];
    assign cpu_irq[c]   = (|src_dev_a[c]) || (|src_mb_a[c]);
  end

  // Read multiplexer; set/clear aliases read back the underlying word.
  always_comb begin
    rd_data = '0;
    case (dec.sel)
      SEL_COUNT: rd_data = 32'(NBITS);
      SEL_RAW, SEL_RAW_SET, SEL_RAW_CLR:
        rd_data = dec.word1 ? 32'(raw_mb) : 32'(raw_dev);
      SEL_SRC:
        rd_data = dec.word1 ? 32'(src_mb_a[cpu_idx]) : 32'(src_dev_a[cpu_idx]);
      SEL_EN, SEL_EN_SET, SEL_EN_CLR:
        rd_data = dec.word1 ? 32'(en_mb_a[cpu_idx]) : 32'(en_dev_a[cpu_idx]);
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? 32'd0 : rd_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata));

  a_r9_one_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r1_count_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_addr == '0) |=> rsp_rdata == 32'(NBITS));

  a_r7_cpu_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.sel inside {SEL_SRC, SEL_EN, SEL_EN_SET, SEL_EN_CLR}) |-> int'(dec.cpu) < NCPU);

endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;

  localparam int NCPU = 4;
  localparam int NDEV = 4;
  localparam int AW   = 12;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'd0,   32'h0,  32'd32, 4'd1},  // R1 count
    '{1'b1, 12'd0,   32'h5,  32'd0,  4'd1},  // R1 write ignored
    '{1'b0, 12'd0,   32'h0,  32'd32, 4'd1},  // R1
    '{1'b0, 12'd12,  32'h0,  32'h0,  4'd8},  // R8 mailbox reset
    '{1'b0, 12'd40,  32'h0,  32'h0,  4'd8},  // R8 enable reset
    '{1'b1, 12'd20,  32'h24, 32'h0,  4'd3},  // R3 set bits 2,5
    '{1'b0, 12'd12,  32'h0,  32'h24, 4'd3},  // R3
    '{1'b1, 12'd20,  32'h1,  32'h0,  4'd3},  // R3
    '{1'b0, 12'd12,  32'h0,  32'h25, 4'd3},  // R3 bits kept
    '{1'b1, 12'd28,  32'h4,  32'h0,  4'd3},  // R3 clear bit 2
    '{1'b0, 12'd12,  32'h0,  32'h21, 4'd3},  // R3
    '{1'b1, 12'd12,  32'hFF, 32'h0,  4'd3},  // R3 plain raw write
    '{1'b0, 12'd12,  32'h0,  32'h21, 4'd3},  // R3 ignored
    '{1'b1, 12'd44,  32'h3,  32'h0,  4'd4},  // R4 cpu0 mb enable plain
    '{1'b0, 12'd44,  32'h0,  32'h3,  4'd4},  // R4
    '{1'b0, 12'd36,  32'h0,  32'h1,  4'd5},  // R5 0x21 & 0x3
    '{1'b1, 12'd52,  32'h20, 32'h0,  4'd4},  // R4 enable set
    '{1'b0, 12'd44,  32'h0,  32'h23, 4'd4},  // R4
    '{1'b1, 12'd60,  32'h1,  32'h0,  4'd4},  // R4 enable clear
    '{1'b0, 12'd44,  32'h0,  32'h22, 4'd4},  // R4
    '{1'b0, 12'd36,  32'h0,  32'h20, 4'd5},  // R5
    '{1'b1, 12'd32,  32'hF,  32'h0,  4'd5},  // R5 source write
    '{1'b0, 12'd32,  32'h0,  32'h0,  4'd5},  // R5 ignored
    '{1'b1, 12'd76,  32'h4,  32'h0,  4'd10}, // R10 cpu1 mb enable
    '{1'b0, 12'd76,  32'h0,  32'h4,  4'd10}, // R10
    '{1'b0, 12'd68,  32'h0,  32'h0,  4'd5},  // R5 0x21 & 0x4
    '{1'b0, 12'd44,  32'h0,  32'h22, 4'd10}, // R10 cpu0 untouched
    '{1'b0, 12'd4,   32'h0,  32'h0,  4'd7},  // R7 hole
    '{1'b1, 12'd4,   32'h1,  32'h0,  4'd7},  // R7
    '{1'b0, 12'd4,   32'h0,  32'h0,  4'd7},  // R7
    '{1'b0, 12'd160, 32'h0,  32'h0,  4'd7},  // R7 past last bank
    '{1'b0, 12'd252, 32'h0,  32'h0,  4'd7},  // R7
    '{1'b1, 12'd136, 32'hFF, 32'h0,  4'd4},  // R4 cpu3 dev enable
    '{1'b0, 12'd136, 32'h0,  32'hF,  4'd4},  // R4 trimmed to NDEV
    '{1'b0, 12'd40,  32'h0,  32'h0,  4'd10}, // R10 cpu0 dev enable
    '{1'b0, 12'd20,  32'h0,  32'h21, 4'd3}   // R3 alias readback
  };

  logic            clk;
  logic            rst_n;
  logic [NDEV-1:0] dev_irq;
  logic            req_valid;
  logic            req_ready;
  logic            req_write;
  logic [AW-1:0]   req_addr;
  logic [31:0]     req_wdata;
  logic            rsp_valid;
  logic            rsp_ready;
  logic [31:0]     rsp_rdata;
  logic [NCPU-1:0] cpu_irq;

  int nchecks = 0;
  int nerr    = 0;
  bit done    = 0;

  irq_aggregator u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_irq  (dev_irq),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata),
    .cpu_irq  (cpu_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One request with rsp_ready high; returns the response sampled at the next negedge.
  task automatic do_op(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] q, output logic v);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    q = rsp_rdata;
    v = rsp_valid;
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] q;
    logic        v;
    do_op(1'b0, a, 32'h0, q, v);
    check(tag, q, exp);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] q;
    logic        v;
    do_op(1'b1, a, d, q, v);
  endtask

  initial begin
    for (int i = 0; i < 50000; i++) @(posedge clk);
    if (!done) begin
      nchecks++;
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    logic        v;
    rst_n     = 1'b0;
    dev_irq   = '0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R8: reset state at the ports
    check("R8 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R8 cpu_irq", 32'(cpu_irq), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 req_ready idle", 32'(req_ready), 32'd1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i].wr, VEC[i].addr, VEC[i].data, q, v);
      check($sformatf("R9 rsp_valid row %0d", i), 32'(v), 32'd1);
      check($sformatf("R%0d row %0d", VEC[i].req, i), q, VEC[i].exp);
    end

    // R6: cpu0 has mailbox bit 5 pending and enabled
    check("R6 irq after table", 32'(cpu_irq), 32'h1);

    // R2: device line lags by one clock
    @(negedge clk);
    dev_irq = 4'b0100;
    #1 check("R2 before edge", 32'(cpu_irq), 32'h1);
    @(negedge clk);
    check("R6 dev irq cpu3", 32'(cpu_irq), 32'h9);
    rd("R2 raw dev word", 12'd8, 32'h4);
    wr(12'd24, 32'hF);
    wr(12'd16, 32'h0);
    wr(12'd8, 32'h0);
    rd("R2 raw dev not writable", 12'd8, 32'h4);
    rd("R5 cpu3 src dev", 12'd128, 32'h4);
    wr(12'd28, 32'h20);
    check("R6 mailbox cleared", 32'(cpu_irq), 32'h8);
    @(negedge clk);
    dev_irq = 4'b0000;
    @(negedge clk);
    check("R6 all quiet", 32'(cpu_irq), 32'h0);

    // R9: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = 12'd0;
    @(negedge clk);
    req_addr = 12'd12;  // second request waits
    check("R9 rsp held valid", 32'(rsp_valid), 32'd1);
    check("R9 req_ready low", 32'(req_ready), 32'd0);
    @(negedge clk);
    @(negedge clk);
    check("R9 data held", rsp_rdata, 32'd32);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 next rsp valid", 32'(rsp_valid), 32'd1);
    check("R9 next rsp data", rsp_rdata, 32'h1);
    @(negedge clk);
    check("R9 drained", 32'(rsp_valid), 32'd0);

    // R8: reset in mid-run
    wr(12'd20, 32'hFF);
    wr(12'd40, 32'hF);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd("R8 mailbox after reset", 12'd12, 32'h0);
    rd("R8 cpu0 mb enable after reset", 12'd44, 32'h0);
    rd("R8 cpu3 dev enable after reset", 12'd136, 32'h0);
    check("R8 cpu_irq after reset", 32'(cpu_irq), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end

endmodule